// File: doc/BRIEF.md
# LED Matrix Scan Refresh Engine

This block keeps a multiplexed LED panel of 128 columns by 32 rows lit from a display memory that is laid out as a 64×64 logical image. It walks the panel one physical row at a time and fetches that row's 128 pixels through the memory's read port, which has one cycle of latency. It turns each 2-bit pixel into on/off column drives over three sub-frames. While the next line is being fetched, it shows the previous line on a 128-bit column bus and drives the physical row index to an external row decoder.

Each physical row is made from two logical rows. The even logical row (counting from 0) feeds the left half of the panel and the odd one feeds the right half. The row decoder settles later than the column drivers, so the column bus is held back by a parameterised number of cycles to keep it in step with the row select. A short all-dark window at every slot boundary hides the moment when the row switches.

The memory sits outside the block. The block only issues read addresses and takes the returned pixel values.

Top module: `ledscan_engine`

## Requirements
- R1: While reset is held, `col_o` is all zero, `row_sel_o` is 0 and `rd_addr_o` is 0.
- R2: Physical column c of physical row r is fetched from address lrow*64 + lcol. For c < 64, lrow = 2r and lcol = c. For c ≥ 64, lrow = 2r+1 and lcol = c−64. Within a slot the addresses are issued one per cycle in ascending column order.
- R3: A slot lasts COLS+2 cycles. `rd_en_o` is high for the first COLS cycles of the slot and low for the last two.
- R4: In a slot with sub-frame index k, column bit c is 1 exactly when the stored 2-bit value is greater than k as an unsigned number. A pixel therefore lights in 0, 1, 2 or 3 of its sub-frames.
- R5: The row index fetched in a slot appears on `row_sel_o` in the first cycle of the following slot. `row_sel_o` only ever steps by +1, wrapping from 31 to 0.
- R6: `col_o` repeats a row-aligned column stream DLY cycles late (default 2). In that stream, the line fetched in slot j is shown during slot j+1.
- R7: The row-aligned column stream is all zero in the last cycle of each slot and in the first BLANK cycles of the next slot.
- R8: Slots are ordered with the sub-frame index fastest. One physical row takes sub-frames 0, 1 and 2 in turn, then the row advances. The first slot after reset is row 0, sub-frame 0.
- R9: Read data is taken from `rd_data_i` in the cycle after its address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en_o | output | 1 | Read request to the display memory |
| rd_addr_o | output | 12 | Display memory read address |
| rd_data_i | input | 2 | Pixel value, valid one cycle after its address |
| row_sel_o | output | 5 | Physical row index to the external row decoder |
| col_o | output | 128 | Column drives, delayed to match the row select |

## Verification
The hardest points to reach are the row wrap from 31 back to 0 and the sub-frame 2 slots. The wrap only happens after 96 slots, roughly 12,500 cycles. In a sub-frame 2 slot only pixels of value 3 light, and this only shows up when the blank window is checked against the delayed column stream. The bench runs every memory pattern for a full frame plus two slots so that each slot boundary, including the wrap, is compared cycle by cycle. The patterns include a uniform value of 1, which lights only in sub-frame 0, and a parity pattern that separates the left and right panel halves.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  localparam int READ_LAT = 1;
  localparam int SLOT_TAIL = READ_LAT + 1;

  function automatic int slot_period(input int cols);
    return cols + SLOT_TAIL;
  endfunction

  function automatic int sub_frames(input int bpp);
    return (1 << bpp) - 1;
  endfunction
endpackage

// File: rtl/lsc_scan_seq.sv
module lsc_scan_seq
  import lsc_pkg::*;
#(
  parameter int COLS = 128,
  parameter int ROWS = 32,
  parameter int BPP  = 2,
  localparam int CW     = $clog2(COLS),
  localparam int RW     = $clog2(ROWS),
  localparam int PERIOD = slot_period(COLS),
  localparam int PW     = $clog2(PERIOD),
  localparam int SUBS   = sub_frames(BPP)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [PW-1:0] ph,
  output logic [RW-1:0] row,
  output logic [BPP-1:0] sub,
  output logic          rd_en,
  output logic [CW-1:0] col,
  output logic          commit
);
  logic last_ph;
  assign last_ph = (ph == PW'(PERIOD - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      ph  <= '0;
      sub <= '0;
      row <= '0;
    end else if (last_ph) begin
      ph <= '0;
      if (sub == BPP'(SUBS - 1)) begin
        sub <= '0;
        row <= (row == RW'(ROWS - 1)) ? '0 : row + RW'(1);
      end else begin
        sub <= sub + BPP'(1);
      end
    end else begin
      ph <= ph + PW'(1);
    end
  end

  assign rd_en  = (ph < PW'(COLS));
  assign col    = ph[CW-1:0];
  assign commit = last_ph;
endmodule

// File: rtl/lsc_line_fill.sv
module lsc_line_fill #(
  parameter int COLS = 128,
  parameter int ROWS = 32,
  parameter int BPP  = 2,
  localparam int CW = $clog2(COLS),
  localparam int RW = $clog2(ROWS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rd_en,
  input  logic [CW-1:0]   col,
  input  logic [BPP-1:0]  sub,
  input  logic [RW-1:0]   row,
  input  logic            commit,
  input  logic [BPP-1:0]  rd_data,
  output logic [COLS-1:0] show_line,
  output logic [RW-1:0]   show_row
);
  logic            v1;
  logic [CW-1:0]   c1;
  logic [BPP-1:0]  s1;
  logic [COLS-1:0] fill_line;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0;
      c1 <= '0;
      s1 <= '0;
    end else begin
      v1 <= rd_en;
      c1 <= col;
      s1 <= sub;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fill_line <= '0;
    end else if (v1) begin
      fill_line[c1] <= (rd_data > s1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      show_line <= '0;
      show_row  <= '0;
    end else if (commit) begin
      show_line <= fill_line;
      show_row  <= row;
    end
  end
endmodule

// File: rtl/lsc_col_align.sv
module lsc_col_align
  import lsc_pkg::*;
#(
  parameter int COLS  = 128,
  parameter int DLY   = 2,
  parameter int BLANK = 1,
  localparam int PERIOD = slot_period(COLS),
  localparam int PW     = $clog2(PERIOD)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PW-1:0]   ph,
  input  logic [COLS-1:0] show_line,
  output logic [COLS-1:0] col_o
);
  logic            dark;
  logic [COLS-1:0] aligned;

  assign dark    = (ph < PW'(BLANK)) || (ph == PW'(PERIOD - 1));
  assign aligned = dark ? '0 : show_line;

  generate
    if (DLY == 0) begin : g_direct
      assign col_o = aligned;
    end else begin : g_pipe
      logic [COLS-1:0] stg [DLY];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < DLY; i++) stg[i] <= '0;
        end else begin
          stg[0] <= aligned;
          for (int i = 1; i < DLY; i++) stg[i] <= stg[i-1];
        end
      end
      assign col_o = stg[DLY-1];
    end
  endgenerate
endmodule

// File: rtl/ledscan_engine.sv
module ledscan_engine
  import lsc_pkg::*;
#(
  parameter int COLS  = 128,
  parameter int ROWS  = 32,
  parameter int BPP   = 2,
  parameter int DLY   = 2,
  parameter int BLANK = 1,
  localparam int CW = $clog2(COLS),
  localparam int RW = $clog2(ROWS),
  localparam int AW = RW + CW,
  localparam int PW = $clog2(slot_period(COLS))
) (
  input  logic            clk,
  input  logic            rst,
  output logic            rd_en_o,
  output logic [AW-1:0]   rd_addr_o,
  input  logic [BPP-1:0]  rd_data_i,
  output logic [RW-1:0]   row_sel_o,
  output logic [COLS-1:0] col_o
);
  logic [PW-1:0]   ph;
  logic [RW-1:0]   fetch_row;
  logic [BPP-1:0]  fetch_sub;
  logic [CW-1:0]   fetch_col;
  logic            commit;
  logic [COLS-1:0] show_line;

  lsc_scan_seq #(.COLS(COLS), .ROWS(ROWS), .BPP(BPP)) u_seq (
    .clk(clk), .rst(rst), .ph(ph), .row(fetch_row), .sub(fetch_sub),
    .rd_en(rd_en_o), .col(fetch_col), .commit(commit)
  );

  // Left half holds the even logical row, right half the odd one: the
  // column MSB picks the row parity, so the address is {row, column}.
  assign rd_addr_o = {fetch_row, fetch_col};

  lsc_line_fill #(.COLS(COLS), .ROWS(ROWS), .BPP(BPP)) u_fill (
    .clk(clk), .rst(rst), .rd_en(rd_en_o), .col(fetch_col), .sub(fetch_sub),
    .row(fetch_row), .commit(commit), .rd_data(rd_data_i),
    .show_line(show_line), .show_row(row_sel_o)
  );

  lsc_col_align #(.COLS(COLS), .DLY(DLY), .BLANK(BLANK)) u_align (
    .clk(clk), .rst(rst), .ph(ph), .show_line(show_line), .col_o(col_o)
  );
endmodule

// File: rtl/ledscan_engine_chk.sv
module ledscan_engine_chk
  import lsc_pkg::*;
#(
  parameter int COLS  = 128,
  parameter int ROWS  = 32,
  parameter int DLY   = 2,
  localparam int CW     = $clog2(COLS),
  localparam int RW     = $clog2(ROWS),
  localparam int AW     = RW + CW,
  localparam int PERIOD = slot_period(COLS),
  localparam int PW     = $clog2(PERIOD)
) (
  input logic            clk,
  input logic            rst,
  input logic            rd_en_o,
  input logic [AW-1:0]   rd_addr_o,
  input logic [RW-1:0]   row_sel_o,
  input logic [COLS-1:0] col_o
);
  logic          ok_past;
  logic [PW-1:0] ph_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      ok_past <= 1'b0;
      ph_seen <= '0;
    end else begin
      ok_past <= 1'b1;
      ph_seen <= (ph_seen == PW'(PERIOD - 1)) ? '0 : ph_seen + PW'(1);
    end
  end

  a_r3_read_window: assert property (@(posedge clk) disable iff (rst)
    rd_en_o == (ph_seen < PW'(COLS)));

  a_r2_addr_step: assert property (@(posedge clk) disable iff (rst)
    ok_past && rd_en_o && $past(rd_en_o) |-> rd_addr_o == $past(rd_addr_o) + AW'(1));

  a_r5_row_at_slot_start: assert property (@(posedge clk) disable iff (rst)
    ok_past && !$stable(row_sel_o) |-> ph_seen == '0);

  a_r5_row_step: assert property (@(posedge clk) disable iff (rst)
    ok_past && !$stable(row_sel_o) |-> row_sel_o == $past(row_sel_o) + RW'(1));

  a_r7_dark_lead: assert property (@(posedge clk) disable iff (rst)
    ph_seen == PW'(DLY % PERIOD) |-> col_o == '0);

  a_r7_dark_trail: assert property (@(posedge clk) disable iff (rst)
    ph_seen == PW'((DLY + PERIOD - 1) % PERIOD) |-> col_o == '0);
endmodule

bind ledscan_engine ledscan_engine_chk #(.COLS(COLS), .ROWS(ROWS), .DLY(DLY)) u_chk (
  .clk(clk), .rst(rst), .rd_en_o(rd_en_o), .rd_addr_o(rd_addr_o),
  .row_sel_o(row_sel_o), .col_o(col_o)
);

// File: tb/sim_ledscan_engine.sv
`timescale 1ns/1ps
module sim_ledscan_engine;
  localparam int COLS = 128;
  localparam int ROWS = 32;
  localparam int DLY  = 2;
  localparam int BLK  = 1;
  localparam int P    = COLS + 2;
  localparam int HALF = COLS / 2;
  localparam int NSLOT = 3 * ROWS + 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic            rd_en;
  logic [11:0]     rd_addr;
  logic [1:0]      rd_data;
  logic [4:0]      row_sel;
  logic [COLS-1:0] cols;

  ledscan_engine u0 (
    .clk(clk), .rst(rst), .rd_en_o(rd_en), .rd_addr_o(rd_addr),
    .rd_data_i(rd_data), .row_sel_o(row_sel), .col_o(cols)
  );

  logic [1:0] mem [4096];
  always_ff @(posedge clk) rd_data <= mem[rd_addr];

  typedef struct packed {
    logic [4:0]      row;
    logic [1:0]      sub;
    logic [COLS-1:0] line;
  } item_t;
  item_t q[$];

  int total = 0;
  int bad = 0;
  bit finished = 0;

  task automatic chk(input string req, input logic [COLS-1:0] act, input logic [COLS-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] pat(input int id, input int a);
    int lr = a / 64;
    int lc = a % 64;
    case (id)
      0: return 2'((lr + lc) % 4);
      1: return 2'd1;
      2: return 2'(((a * 37) ^ (a >> 3)) % 4);
      default: return (lr % 2 == 1) ? 2'd3 : 2'd0;
    endcase
  endfunction

  // driver: loads the memory and queues the line expected for every slot
  task automatic drive(input int id);
    for (int a = 0; a < 4096; a++) mem[a] = pat(id, a);
    q.delete();
    for (int j = 0; j < NSLOT; j++) begin
      item_t it;
      it.row = 5'((j / 3) % ROWS);
      it.sub = 2'(j % 3);
      for (int c = 0; c < COLS; c++) begin
        int lrow = 2 * int'(it.row) + c / HALF;
        int lcol = c % HALF;
        it.line[c] = (mem[lrow * 64 + lcol] > it.sub);
      end
      q.push_back(it);
    end
  endtask

  // monitor: pops one queued line per slot and compares every cycle
  task automatic monitor();
    item_t cur = '0;
    item_t prv = '0;
    @(posedge clk);
    for (int t = 1; t < NSLOT * P; t++) begin
      int s = t / P;
      int ph = t % P;
      int u = t - DLY;
      logic [COLS-1:0] ecol;
      int erow;
      int eaddr;
      @(negedge clk);
      if (ph == 0 && s >= 1) begin
        prv = cur;
        cur = q.pop_front();
      end
      erow = (s >= 1) ? int'(cur.row) : 0;
      chk("R5 R8 row_sel", COLS'(row_sel), COLS'(erow));
      chk("R3 rd_en", COLS'(rd_en), COLS'(ph < COLS));
      if (ph < COLS) begin
        int r = (s / 3) % ROWS;
        int lrow = 2 * r + ph / HALF;
        eaddr = lrow * 64 + ph % HALF;
        chk("R2 R8 rd_addr", COLS'(rd_addr), COLS'(eaddr));
      end
      if (u < 0) begin
        chk("R6 col pipe start", cols, '0);
      end else begin
        int su = u / P;
        int pu = u % P;
        if (pu < BLK || pu == P - 1) begin
          chk("R7 dark window", cols, '0);
        end else begin
          if (su == 0) ecol = '0;
          else if (su == s) ecol = cur.line;
          else ecol = prv.line;
          chk("R4 R6 R9 col", cols, ecol);
        end
      end
    end
  endtask

  initial begin
    for (int id = 0; id < 4; id++) begin
      drive(id);
      rst = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 reset col", cols, '0);
      chk("R1 reset row", COLS'(row_sel), '0);
      chk("R1 reset addr", COLS'(rd_addr), '0);
      rst = 1'b0;
      monitor();
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule